// File: doc/BRIEF.md
# Queue Delay Snippet Cloner

This block sits on the dequeue side of a set of packet queues. Each packet arrives as a stream of beats. Its first beat carries a queue number and the timestamp taken when the packet was enqueued. The block forwards every beat to its main output exactly as it arrives, and it never holds back the main path.

When the first beat is accepted, the block subtracts the enqueue timestamp from the current time to get the time the packet spent queued. It then compares that delay with the threshold and the enable bit configured for the packet's queue. If the delay is strictly greater than the threshold, the block copies the leading bytes of the packet, up to 150 of them, onto a second output stream. The copy carries the queue number and the measured delay as sideband, so that a downstream stage can put a telemetry header in front of it and send it on.

If the clone consumer cannot take a snippet at the moment of the decision, the snippet is skipped and a wrapping counter of skipped snippets advances.

Top module: `hdc_clone_trigger`

## Requirements
- R1: The main output equals the input on every cycle: out_valid, out_data, out_last, out_nbytes, out_qid and out_enq_ts follow the inputs of the same cycle, and in_ready equals out_ready, whatever the clone path is doing.
- R2: The delay is (now_ts - in_enq_ts) modulo 2^32, taken on the cycle the first beat is accepted. The delay and the queue number appear on cl_delay and cl_qid on every beat of the snippet, so a timestamp counter wrap still gives the correct delay.
- R3: A snippet starts only when the delay is strictly greater than the threshold. A delay equal to the threshold, or below it, starts no snippet.
- R4: Each queue q has its own enable bit, cfg_enable[q], and its own threshold, cfg_thresh[32q+31:32q]. All queues may be enabled at once, and a queue whose enable bit is 0 never starts a snippet.
- R5: A snippet beat (cl_valid=1) occurs only in a cycle where a main beat is accepted (in_valid and out_ready both 1). It carries that beat's bytes, starting from the first byte of the packet.
- R6: The snippet holds min(packet length, 150) bytes. cl_nbytes gives the valid byte count of each beat. Byte lane k sits at bits [8k+7:8k], lane 0 is the earliest byte, and lanes at or above cl_nbytes are zero. cl_last is 1 on exactly one beat, the final beat of the snippet.
- R7: cl_ready is looked at only on the first beat of a packet. If a snippet would start while cl_ready is 0, no beat of that packet is cloned and drop_count advances by one. Once a snippet has started, its remaining beats go out whatever the value of cl_ready.
- R8: The enable bit and the threshold are used only on a packet's first beat. A change to either during the packet does not alter the decision for that packet.
- R9: After reset, cl_valid is 0, drop_count is 0, and the next accepted beat is treated as the first beat of a packet, even if reset arrived in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | NUM_Q | Per-queue capture enable |
| cfg_thresh | input | NUM_Q*TS_W | Per-queue delay threshold, queue q at bits [TS_W*q +: TS_W] |
| now_ts | input | TS_W | Current time |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat ready (equals out_ready) |
| in_data | input | 8*BEAT_BYTES | Input beat bytes, lane 0 first |
| in_last | input | 1 | Final beat of the packet |
| in_nbytes | input | $clog2(BEAT_BYTES+1) | Valid bytes in the final beat; full on other beats |
| in_qid | input | QID_W | Queue number |
| in_enq_ts | input | TS_W | Enqueue timestamp of the packet |
| out_valid | output | 1 | Main beat valid |
| out_ready | input | 1 | Main sink ready |
| out_data | output | 8*BEAT_BYTES | Main beat bytes |
| out_last | output | 1 | Main final beat |
| out_nbytes | output | $clog2(BEAT_BYTES+1) | Main byte count |
| out_qid | output | QID_W | Main queue number |
| out_enq_ts | output | TS_W | Main enqueue timestamp |
| cl_valid | output | 1 | Snippet beat valid |
| cl_ready | input | 1 | Consumer has room for a full snippet (looked at on first beats) |
| cl_data | output | 8*BEAT_BYTES | Snippet bytes, unused lanes zero |
| cl_last | output | 1 | Final snippet beat |
| cl_nbytes | output | $clog2(BEAT_BYTES+1) | Valid bytes in this snippet beat |
| cl_qid | output | QID_W | Queue number of the cloned packet |
| cl_delay | output | TS_W | Measured queueing delay |
| drop_count | output | DROP_W | Snippets skipped for lack of room, wrapping |

## Verification
A corrupted beat counter or phase flag shows up within one packet. Either the main stream is mistaken for a first beat, so a snippet starts in mid-packet with the wrong bytes, or the next packet's first beat is missed and its snippet never appears. A byte-count error moves cl_last away from the 150th byte, or lets nonzero data leak into lanes past cl_nbytes, on the beat where the cut falls. A stale held delay or queue number changes cl_delay or cl_qid on the second snippet beat. The bench compares each of these per beat and per packet against values it derives from the timestamps and the configured thresholds.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

  // Position of the input stream within a packet
  typedef enum logic {
    PH_HEAD = 1'b0,
    PH_BODY = 1'b1
  } pkt_phase_e;

  // Whether the packet currently on the input is being copied
  typedef enum logic {
    CLN_OFF = 1'b0,
    CLN_ON  = 1'b1
  } clone_st_e;

  // Bytes copied from a beat: what the beat offers, capped by what the snippet still has room for
  function automatic logic [31:0] take_bytes(input logic [31:0] avail, input logic [31:0] room);
    return (avail < room) ? avail : room;
  endfunction

endpackage

// File: rtl/hdc_delay_eval.sv
module hdc_delay_eval #(
  parameter  int unsigned NUM_Q = 4,
  parameter  int unsigned TS_W  = 32,
  localparam int unsigned QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic [TS_W-1:0]       now_ts,
  input  logic [TS_W-1:0]       enq_ts,
  input  logic [QID_W-1:0]      qid,
  input  logic [NUM_Q-1:0]      cfg_enable,
  input  logic [NUM_Q*TS_W-1:0] cfg_thresh,
  output logic [TS_W-1:0]       delay,
  output logic                  trig
);

  // Modular difference, so a wrapped clock still yields the elapsed time
  function automatic logic [TS_W-1:0] span(input logic [TS_W-1:0] t_late,
                                           input logic [TS_W-1:0] t_early);
    return t_late - t_early;
  endfunction

  // Strict comparison: a delay equal to the limit does not count
  function automatic logic exceeds(input logic [TS_W-1:0] d, input logic [TS_W-1:0] lim);
    return d > lim;
  endfunction

  logic [NUM_Q-1:0] hit;

  assign delay = span(now_ts, enq_ts);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    assign hit[g] = (qid == QID_W'(g)) && cfg_enable[g]
                    && exceeds(delay, cfg_thresh[g*TS_W +: TS_W]);
  end

  assign trig = |hit;

endmodule

// File: rtl/hdc_snip_tracker.sv
module hdc_snip_tracker
  import hdc_pkg::*;
#(
  parameter  int unsigned BEAT_BYTES = 16,
  parameter  int unsigned SNIP_BYTES = 150,
  localparam int unsigned NB_W       = $clog2(BEAT_BYTES + 1),
  localparam int unsigned SENT_W     = $clog2(SNIP_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat_fire,
  input  logic            head_beat,
  input  logic            tail_beat,
  input  logic            start_ok,
  input  logic [NB_W-1:0] beat_nbytes,
  output logic            clone_on,
  output logic [NB_W-1:0] clone_nbytes,
  output logic            clone_last
);

  clone_st_e         st_q;
  logic [SENT_W-1:0] sent_q;
  logic              live;
  logic [SENT_W-1:0] sent_base;
  logic [SENT_W-1:0] room;
  logic [31:0]       take_u;
  logic [SENT_W-1:0] take_w;

  // On a first beat the decision is made now; later beats follow the stored state
  assign live      = head_beat ? start_ok : (st_q == CLN_ON);
  assign sent_base = head_beat ? '0 : sent_q;
  assign room      = SENT_W'(SNIP_BYTES) - sent_base;
  assign take_u    = take_bytes(32'(beat_nbytes), 32'(room));
  assign take_w    = SENT_W'(take_u);

  assign clone_on     = beat_fire && live && (room != '0);
  assign clone_nbytes = clone_on ? NB_W'(take_u) : '0;
  assign clone_last   = clone_on && (tail_beat || (take_w == room));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CLN_OFF;
      sent_q <= '0;
    end else if (beat_fire) begin
      if (clone_on) begin
        sent_q <= sent_base + take_w;
        st_q   <= clone_last ? CLN_OFF : CLN_ON;
      end else begin
        st_q   <= CLN_OFF;
      end
    end
  end

endmodule

// File: rtl/hdc_drop_ctr.sv
module hdc_drop_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/hdc_clone_trigger.sv
module hdc_clone_trigger
  import hdc_pkg::*;
#(
  parameter  int unsigned NUM_Q      = 4,
  parameter  int unsigned BEAT_BYTES = 16,
  parameter  int unsigned TS_W       = 32,
  parameter  int unsigned SNIP_BYTES = 150,
  parameter  int unsigned DROP_W     = 16,
  localparam int unsigned QID_W      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int unsigned NB_W       = $clog2(BEAT_BYTES + 1),
  localparam int unsigned DW         = 8 * BEAT_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_Q-1:0]      cfg_enable,
  input  logic [NUM_Q*TS_W-1:0] cfg_thresh,
  input  logic [TS_W-1:0]       now_ts,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DW-1:0]         in_data,
  input  logic                  in_last,
  input  logic [NB_W-1:0]       in_nbytes,
  input  logic [QID_W-1:0]      in_qid,
  input  logic [TS_W-1:0]       in_enq_ts,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DW-1:0]         out_data,
  output logic                  out_last,
  output logic [NB_W-1:0]       out_nbytes,
  output logic [QID_W-1:0]      out_qid,
  output logic [TS_W-1:0]       out_enq_ts,
  output logic                  cl_valid,
  input  logic                  cl_ready,
  output logic [DW-1:0]         cl_data,
  output logic                  cl_last,
  output logic [NB_W-1:0]       cl_nbytes,
  output logic [QID_W-1:0]      cl_qid,
  output logic [TS_W-1:0]       cl_delay,
  output logic [DROP_W-1:0]     drop_count
);

  // Events brought out as named wires for the checker
  logic            beat_fire;
  logic            head_beat;
  logic            trig;
  logic            start_ok;
  logic            start_fail;
  logic            clone_first;

  pkt_phase_e      phase_q;
  logic [TS_W-1:0] cur_delay;
  logic [TS_W-1:0] delay_q;
  logic [QID_W-1:0] qid_q;
  logic [NB_W-1:0] beat_nbytes;

  // Main path: pure pass-through, never stalled by the clone side
  assign out_valid  = in_valid;
  assign out_data   = in_data;
  assign out_last   = in_last;
  assign out_nbytes = in_nbytes;
  assign out_qid    = in_qid;
  assign out_enq_ts = in_enq_ts;
  assign in_ready   = out_ready;

  assign beat_fire = in_valid && out_ready;
  assign head_beat = (phase_q == PH_HEAD);

  always_ff @(posedge clk) begin
    if (!rst_n)         phase_q <= PH_HEAD;
    else if (beat_fire) phase_q <= in_last ? PH_HEAD : PH_BODY;
  end

  hdc_delay_eval #(
    .NUM_Q (NUM_Q),
    .TS_W  (TS_W)
  ) u_eval (
    .now_ts     (now_ts),
    .enq_ts     (in_enq_ts),
    .qid        (in_qid),
    .cfg_enable (cfg_enable),
    .cfg_thresh (cfg_thresh),
    .delay      (cur_delay),
    .trig       (trig)
  );

  // Decision taken once per packet, on its first beat
  assign start_ok   = trig && cl_ready;
  assign start_fail = beat_fire && head_beat && trig && !cl_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qid_q   <= '0;
      delay_q <= '0;
    end else if (beat_fire && head_beat) begin
      qid_q   <= in_qid;
      delay_q <= cur_delay;
    end
  end

  assign cl_qid   = head_beat ? in_qid : qid_q;
  assign cl_delay = head_beat ? cur_delay : delay_q;

  assign beat_nbytes = in_last ? in_nbytes : NB_W'(BEAT_BYTES);

  hdc_snip_tracker #(
    .BEAT_BYTES (BEAT_BYTES),
    .SNIP_BYTES (SNIP_BYTES)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_fire    (beat_fire),
    .head_beat    (head_beat),
    .tail_beat    (in_last),
    .start_ok     (start_ok),
    .beat_nbytes  (beat_nbytes),
    .clone_on     (cl_valid),
    .clone_nbytes (cl_nbytes),
    .clone_last   (cl_last)
  );

  assign clone_first = cl_valid && head_beat;

  // Lanes past the snippet byte count are zeroed
  for (genvar b = 0; b < BEAT_BYTES; b++) begin : g_lane
    assign cl_data[8*b +: 8] = (NB_W'(b) < cl_nbytes) ? in_data[8*b +: 8] : 8'h00;
  end

  hdc_drop_ctr #(
    .CNT_W (DROP_W)
  ) u_drops (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (start_fail),
    .count (drop_count)
  );

endmodule

// File: rtl/hdc_clone_trigger_chk.sv
module hdc_clone_trigger_chk #(
  parameter int unsigned BEAT_BYTES = 16,
  parameter int unsigned SNIP_BYTES = 150,
  parameter int unsigned TS_W       = 32,
  parameter int unsigned QID_W      = 2,
  parameter int unsigned DROP_W     = 16,
  parameter int unsigned NB_W       = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_last,
  input logic              out_ready,
  input logic              cl_valid,
  input logic              cl_last,
  input logic [NB_W-1:0]   cl_nbytes,
  input logic [QID_W-1:0]  cl_qid,
  input logic [TS_W-1:0]   cl_delay,
  input logic [DROP_W-1:0] drop_count,
  input logic              start_fail,
  input logic              trig,
  input logic              clone_first
);

  localparam int unsigned SUM_W = $clog2(SNIP_BYTES + BEAT_BYTES + 1);

  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] sum_now;

  // Independent running total of snippet bytes
  assign sum_now = acc_q + SUM_W'(cl_nbytes);

  always_ff @(posedge clk) begin
    if (!rst_n)        acc_q <= '0;
    else if (cl_valid) acc_q <= cl_last ? '0 : sum_now;
  end

  assert_clone_rides_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cl_valid |-> (in_valid && out_ready));

  assert_snip_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cl_valid |-> (sum_now <= SUM_W'(SNIP_BYTES)));

  assert_snip_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_valid && cl_last) |-> (in_last || (sum_now == SUM_W'(SNIP_BYTES))));

  assert_start_needs_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clone_first |-> trig);

  assert_meta_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_valid && !cl_last) |=> ($stable(cl_delay) && $stable(cl_qid)));

  assert_skip_no_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_fail |-> !cl_valid);

  assert_drop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_fail |=> (drop_count == $past(drop_count) + 1'b1));

  assert_drop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_fail |=> $stable(drop_count));

endmodule

bind hdc_clone_trigger hdc_clone_trigger_chk #(
  .BEAT_BYTES (BEAT_BYTES),
  .SNIP_BYTES (SNIP_BYTES),
  .TS_W       (TS_W),
  .QID_W      (QID_W),
  .DROP_W     (DROP_W),
  .NB_W       (NB_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_last     (in_last),
  .out_ready   (out_ready),
  .cl_valid    (cl_valid),
  .cl_last     (cl_last),
  .cl_nbytes   (cl_nbytes),
  .cl_qid      (cl_qid),
  .cl_delay    (cl_delay),
  .drop_count  (drop_count),
  .start_fail  (start_fail),
  .trig        (trig),
  .clone_first (clone_first)
);

// File: tb/hdc_clone_trigger_tb.sv
module hdc_clone_trigger_tb;

  localparam int CLK_P = 10;
  localparam int NQ    = 4;
  localparam int DB    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NQ-1:0] cfg_enable;
  logic [NQ*32-1:0] cfg_thresh;
  logic [31:0]   now_ts;
  logic          in_valid, in_ready, in_last;
  logic [8*DB-1:0] in_data;
  logic [4:0]    in_nbytes;
  logic [1:0]    in_qid;
  logic [31:0]   in_enq_ts;
  logic          out_valid, out_ready, out_last;
  logic [8*DB-1:0] out_data;
  logic [4:0]    out_nbytes;
  logic [1:0]    out_qid;
  logic [31:0]   out_enq_ts;
  logic          cl_valid, cl_ready, cl_last;
  logic [8*DB-1:0] cl_data;
  logic [4:0]    cl_nbytes;
  logic [1:0]    cl_qid;
  logic [31:0]   cl_delay;
  logic [15:0]   drop_count;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  hdc_clone_trigger u_dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_enable (cfg_enable), .cfg_thresh (cfg_thresh), .now_ts (now_ts),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data), .in_last (in_last),
    .in_nbytes (in_nbytes), .in_qid (in_qid), .in_enq_ts (in_enq_ts),
    .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data), .out_last (out_last),
    .out_nbytes (out_nbytes), .out_qid (out_qid), .out_enq_ts (out_enq_ts),
    .cl_valid (cl_valid), .cl_ready (cl_ready), .cl_data (cl_data), .cl_last (cl_last),
    .cl_nbytes (cl_nbytes), .cl_qid (cl_qid), .cl_delay (cl_delay), .drop_count (drop_count)
  );

  typedef struct packed {
    logic [1:0]  q;
    logic [31:0] enq;
    logic [31:0] now;
    logic [15:0] len;
    logic        clr;
    logic [7:0]  exp_bytes;
    logic        exp_drop;
  } vec_t;

  // Thresholds: q0=100, q1=0, q2=1000, q3=50 but disabled
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'd1000,       32'd1101,       16'd200, 1'b1, 8'd150, 1'b0}, // R3 101>100, cut at 150 R6
    '{2'd0, 32'd1000,       32'd1100,       16'd64,  1'b1, 8'd0,   1'b0}, // R3 equal: no snippet
    '{2'd1, 32'd5,          32'd6,          16'd40,  1'b1, 8'd40,  1'b0}, // R4 zero threshold
    '{2'd1, 32'd7,          32'd7,          16'd40,  1'b1, 8'd0,   1'b0}, // R3 zero delay
    '{2'd3, 32'd0,          32'd5000,       16'd30,  1'b1, 8'd0,   1'b0}, // R4 disabled queue
    '{2'd2, 32'hFFFF_FF00,  32'h0000_0100,  16'd80,  1'b1, 8'd0,   1'b0}, // R2 wrap, 512 < 1000
    '{2'd2, 32'hFFFF_FF00,  32'h0000_0400,  16'd150, 1'b1, 8'd150, 1'b0}, // R2 wrap, 1280 > 1000
    '{2'd0, 32'd0,          32'd500,        16'd100, 1'b0, 8'd0,   1'b1}, // R7 no room: skip
    '{2'd1, 32'd10,         32'd20,         16'd16,  1'b1, 8'd16,  1'b0}, // single beat
    '{2'd2, 32'd0,          32'd2000,       16'd151, 1'b1, 8'd150, 1'b0}, // R6 one past the cap
    '{2'd1, 32'd0,          32'd3,          16'd1,   1'b1, 8'd1,   1'b0}  // one byte packet
  };

  function automatic logic [7:0] byte_val(input int pid, input int idx);
    return 8'((pid * 37 + idx * 3 + 1) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_pkt(input int pid, input logic [1:0] q, input logic [31:0] enq,
                          input logic [31:0] now, input int len, input logic clr,
                          input int exp_bytes, input logic exp_drop,
                          input int chg_q, input logic [31:0] chg_thr);
    int nbeats;
    int got_bytes;
    int main_bad;
    int clone_bad;
    int meta_bad;
    int last_cnt;
    logic [15:0] drop0;
    nbeats    = (len + DB - 1) / DB;
    got_bytes = 0;
    main_bad  = 0;
    clone_bad = 0;
    meta_bad  = 0;
    last_cnt  = 0;
    drop0     = drop_count;
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      if (b == 1 && chg_q >= 0) cfg_thresh[chg_q*32 +: 32] = chg_thr;
      in_valid  = 1'b1;
      in_last   = (b == nbeats - 1);
      in_nbytes = in_last ? 5'(len - DB * b) : 5'(DB);
      for (int k = 0; k < DB; k++) in_data[8*k +: 8] = byte_val(pid, DB * b + k);
      in_qid    = q;
      in_enq_ts = enq;
      now_ts    = now;
      cl_ready  = (b == 0) ? clr : 1'b0;
      #1;
      if (out_valid !== 1'b1 || out_data !== in_data || out_last !== in_last ||
          out_nbytes !== in_nbytes || out_qid !== in_qid || out_enq_ts !== in_enq_ts ||
          in_ready !== 1'b1) main_bad++;
      if (cl_valid === 1'b1) begin
        if (cl_qid !== q || cl_delay !== (now - enq)) meta_bad++;
        for (int k = 0; k < DB; k++) begin
          if (k < int'(cl_nbytes)) begin
            if (cl_data[8*k +: 8] !== byte_val(pid, DB * b + k)) clone_bad++;
          end else if (cl_data[8*k +: 8] !== 8'h00) clone_bad++;
        end
        if (got_bytes != DB * b) clone_bad++;
        got_bytes += int'(cl_nbytes);
        if (cl_last === 1'b1) last_cnt++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    cl_ready = 1'b1;
    #1;
    check(main_bad == 0, "R1", "main beats differing from input", main_bad, 0);
    check(got_bytes == exp_bytes, "R3 R4 R6", "snippet bytes", got_bytes, exp_bytes);
    check(last_cnt == (exp_bytes > 0 ? 1 : 0), "R6", "snippet end markers",
          last_cnt, (exp_bytes > 0 ? 1 : 0));
    check(clone_bad == 0, "R5", "snippet lane mismatches", clone_bad, 0);
    check(meta_bad == 0, "R2", "delay/queue sideband mismatches", meta_bad, 0);
    check(drop_count == 16'(drop0 + exp_drop), "R7", "skip counter",
          drop_count, 16'(drop0 + exp_drop));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfg_enable = 4'b0111;
    cfg_thresh = '0;
    cfg_thresh[0*32 +: 32] = 32'd100;
    cfg_thresh[1*32 +: 32] = 32'd0;
    cfg_thresh[2*32 +: 32] = 32'd1000;
    cfg_thresh[3*32 +: 32] = 32'd50;
    now_ts = '0; in_valid = 0; in_data = '0; in_last = 0; in_nbytes = '0;
    in_qid = '0; in_enq_ts = '0; out_ready = 1; cl_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R9: state out of reset
    check(cl_valid == 1'b0, "R9", "cl_valid after reset", cl_valid, 0);
    check(drop_count == 16'd0, "R9", "drop_count after reset", drop_count, 0);
    check(out_valid == 1'b0, "R1", "out_valid idle", out_valid, 0);

    for (int i = 0; i < NV; i++)
      send_pkt(i + 1, VECS[i].q, VECS[i].enq, VECS[i].now, int'(VECS[i].len), VECS[i].clr,
               int'(VECS[i].exp_bytes), VECS[i].exp_drop, -1, 32'd0);

    // R8: raising the threshold mid-packet keeps the snippet going
    send_pkt(40, 2'd0, 32'd0, 32'd101, 64, 1'b1, 64, 1'b0, 0, 32'd500);
    cfg_thresh[0 +: 32] = 32'd100;
    // R8: lowering it mid-packet does not start one late
    cfg_thresh[0 +: 32] = 32'd500;
    send_pkt(41, 2'd0, 32'd0, 32'd101, 64, 1'b1, 0, 1'b0, 0, 32'd100);
    cfg_thresh[0 +: 32] = 32'd100;

    // R4: all queues enabled at once, queue 3 now captures
    cfg_enable = 4'b1111;
    send_pkt(42, 2'd3, 32'd0, 32'd51, 20, 1'b1, 20, 1'b0, -1, 32'd0);

    // R5 / R1: main sink stalled, nothing accepted, nothing cloned, nothing skipped
    begin
      logic [15:0] d0;
      d0 = drop_count;
      @(negedge clk);
      in_valid = 1; in_last = 1; in_nbytes = 5'd16; in_qid = 2'd0;
      in_enq_ts = 32'd0; now_ts = 32'd900; cl_ready = 0; out_ready = 0;
      #1;
      check(in_ready == 1'b0, "R1", "in_ready under stall", in_ready, 0);
      check(cl_valid == 1'b0, "R5", "cl_valid under stall", cl_valid, 0);
      @(negedge clk);
      in_valid = 0; out_ready = 1; cl_ready = 1;
      #1;
      check(drop_count == d0, "R7", "skip counter under stall", drop_count, d0);
    end

    // R9: reset in mid-packet, then a fresh packet is seen as a first beat
    @(negedge clk);
    in_valid = 1; in_last = 0; in_nbytes = 5'd16; in_qid = 2'd0;
    in_enq_ts = 32'd0; now_ts = 32'd700; cl_ready = 0;
    @(negedge clk);
    in_valid = 0; rst_n = 0; cl_ready = 1;
    @(negedge clk);
    rst_n = 1;
    #1;
    check(drop_count == 16'd0, "R9", "drop_count cleared by reset", drop_count, 0);
    send_pkt(50, 2'd1, 32'd0, 32'd9, 48, 1'b1, 48, 1'b0, -1, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule